// File: doc/BRIEF.md
# Predicated Vector Unary Lane Unit

This block applies one unary operation to every element of a 128-bit source vector. It then writes the result into a copy of the old destination vector under a 16-bit byte-enable mask. The elements are 8, 16, 32 or 64 bits wide. The operations are:

- a count of leading zeros;
- a count of redundant leading sign bits;
- a reversal of bytes, halfwords or words inside each element;
- a bitwise inversion.

A vector pipeline places it after operand read. Mask generation, predicate bookkeeping and register-file access belong to the surrounding logic.

The datapath is combinational and ends in one output register. A request presented with `valid_i` high appears on the outputs on the following clock edge. An operation that is not defined at the requested element size is refused: the old destination is passed through unchanged and an error flag is raised.

Top module: `vul_unary_lane`

## Requirements
- R1: Destination byte j (bits 8j+7..8j) takes the operation result only when mask bit j is 1. Otherwise it keeps the old destination byte, even when other bytes of the same element are enabled.
- R2: Operation code 1 (leading zeros) works at size code 0, 1 or 2 (8, 16 or 32 bits). It returns the number of leading zero bits of each element, counted at the element width, so an all-zero element yields its width. The count is zero-extended into that element. Element 0 sits in the lowest bytes.
- R3: Operation code 0 (leading sign bits) works at size code 0, 1 or 2. It returns, for each element, how many bits below the top bit equal the top bit. An all-zero or all-one element yields width minus 1.
- R4: Operation code 2 reverses the byte order inside each element of size code 1, 2 or 3 (16, 32 or 64 bits).
- R5: Operation code 3 reverses the halfword order inside each element of size code 2 or 3.
- R6: Operation code 4 swaps the two 32-bit words inside each element of size code 3.
- R7: Operation code 5 inverts all 128 source bits under the byte mask, and the size code has no effect on its result.
- R8: The following requests are invalid:
  - leading zeros or leading sign bits at size code 3;
  - code 2 at size 0;
  - code 3 at size 0 or 1;
  - code 4 below size 3;
  - codes 6 and 7.

  An invalid request sets `err_o` to 1 and returns the old destination unchanged. A valid request returns `err_o` 0.
- R9: `valid_o` is `valid_i` delayed by one clock. Results and the error flag are due on the same edge.
- R10: While `rst_ni` is low, `valid_o`, `err_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| esize_i | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Old destination vector |
| mask_i | input | 16 | Byte enables, bit j gates byte j |
| valid_o | output | 1 | Result strobe |
| result_o | output | 128 | Merged destination vector |
| err_o | output | 1 | Invalid operation and size pairing |

## Verification
Every result is due on the first rising edge after the edge that samples the request, one register deep. The bench therefore drives a request at a falling edge and compares `result_o`, `err_o` and `valid_o` at the next falling edge, half a period after that register has loaded. The next falling edge confirms that `valid_o` has dropped again. The expected vector comes from a behavioural model in the bench that works element by element with integer arithmetic and then applies the byte merge.

// File: rtl/vul_pkg.sv
package vul_pkg;
  typedef enum logic [2:0] {
    OP_CLS  = 3'd0,
    OP_CLZ  = 3'd1,
    OP_REVB = 3'd2,
    OP_REVH = 3'd3,
    OP_REVW = 3'd4,
    OP_NOT  = 3'd5
  } vul_op_e;

  localparam int unsigned VUL_OP_W = 3;
  localparam int unsigned VUL_SZ_W = 2;
endpackage

// File: rtl/vul_count.sv
module vul_count #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [1:0]       esize_i,
  input  logic             sign_i,
  output logic [VEC_W-1:0] cnt_o
);
  localparam int unsigned N8  = VEC_W / 8;
  localparam int unsigned N16 = VEC_W / 16;
  localparam int unsigned N32 = VEC_W / 32;

  // run length below the top (sign mode) or from the top (zero mode)
  function automatic logic [5:0] lead_run(input logic [31:0] x, input int unsigned w,
                                          input logic sgn);
    logic refb;
    logic run;
    logic [5:0] cnt;
    int unsigned top;
    refb = sgn ? x[w-1] : 1'b0;
    top  = sgn ? w - 1 : w;
    run  = 1'b1;
    cnt  = '0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(top)) begin
        if (run && (x[i] == refb)) cnt = cnt + 6'd1;
        else run = 1'b0;
      end
    end
    return cnt;
  endfunction

  logic [5:0] c8  [N8];
  logic [5:0] c16 [N16];
  logic [5:0] c32 [N32];

  for (genvar g = 0; g < N8; g++) begin : g_b
    assign c8[g] = lead_run({24'b0, src_i[8*g +: 8]}, 8, sign_i);
  end
  for (genvar g = 0; g < N16; g++) begin : g_h
    assign c16[g] = lead_run({16'b0, src_i[16*g +: 16]}, 16, sign_i);
  end
  for (genvar g = 0; g < N32; g++) begin : g_w
    assign c32[g] = lead_run(src_i[32*g +: 32], 32, sign_i);
  end

  always_comb begin
    cnt_o = '0;
    unique case (esize_i)
      2'd0: for (int i = 0; i < N8; i++)  cnt_o[8*i +: 8]   = {2'b0, c8[i]};
      2'd1: for (int i = 0; i < N16; i++) cnt_o[16*i +: 16] = {10'b0, c16[i]};
      2'd2: for (int i = 0; i < N32; i++) cnt_o[32*i +: 32] = {26'b0, c32[i]};
      default: cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/vul_reverse.sv
module vul_reverse #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_i,
  input  logic [1:0]       unit_log2_i,
  input  logic [1:0]       cont_log2_i,
  output logic [VEC_W-1:0] rev_o
);
  localparam int unsigned NB = VEC_W / 8;

  always_comb begin
    rev_o = '0;
    for (int b = 0; b < NB; b++) begin
      int c, u, off, sb;
      c   = 1 << cont_log2_i;
      u   = 1 << unit_log2_i;
      off = b % c;
      sb  = (b - off) + (c / u - 1 - off / u) * u + off % u;
      rev_o[8*b +: 8] = src_i[8*sb +: 8];
    end
  end
endmodule

// File: rtl/vul_merge.sv
module vul_merge #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0]   new_i,
  input  logic [VEC_W-1:0]   old_i,
  input  logic [VEC_W/8-1:0] en_i,
  output logic [VEC_W-1:0]   out_o
);
  for (genvar j = 0; j < VEC_W / 8; j++) begin : g_byte
    assign out_o[8*j +: 8] = en_i[j] ? new_i[8*j +: 8] : old_i[8*j +: 8];
  end
endmodule

// File: rtl/vul_unary_lane.sv
module vul_unary_lane
  import vul_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic [1:0]         esize_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   dst_i,
  input  logic [VEC_W/8-1:0] mask_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   result_o,
  output logic               err_o
);
  localparam int unsigned NB = VEC_W / 8;

  vul_op_e          op;
  logic [VEC_W-1:0] cnt, rev, res, merged;
  logic [1:0]       unit_log2;
  logic             legal;

  assign op = vul_op_e'(op_i);

  vul_count #(.VEC_W(VEC_W)) u_count (
    .src_i  (src_i),
    .esize_i(esize_i),
    .sign_i (op == OP_CLS),
    .cnt_o  (cnt)
  );

  vul_reverse #(.VEC_W(VEC_W)) u_rev (
    .src_i      (src_i),
    .unit_log2_i(unit_log2),
    .cont_log2_i(esize_i),
    .rev_o      (rev)
  );

  always_comb begin
    legal     = 1'b0;
    res       = '0;
    unit_log2 = 2'd0;
    unique case (op)
      OP_CLS, OP_CLZ: begin
        legal = (esize_i != 2'd3);
        res   = cnt;
      end
      OP_REVB: begin
        unit_log2 = 2'd0;
        legal     = (esize_i > 2'd0);
        res       = rev;
      end
      OP_REVH: begin
        unit_log2 = 2'd1;
        legal     = (esize_i > 2'd1);
        res       = rev;
      end
      OP_REVW: begin
        unit_log2 = 2'd2;
        legal     = (esize_i == 2'd3);
        res       = rev;
      end
      OP_NOT: begin
        legal = 1'b1;
        res   = ~src_i;
      end
      default: legal = 1'b0;
    endcase
  end

  vul_merge #(.VEC_W(VEC_W)) u_merge (
    .new_i(res),
    .old_i(dst_i),
    .en_i (legal ? mask_i : {NB{1'b0}}),
    .out_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= merged;
        err_o    <= ~legal;
      end
    end
  end
endmodule

// File: rtl/vul_unary_chk.sv
module vul_unary_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [2:0]         op_i,
  input logic [1:0]         esize_i,
  input logic [VEC_W-1:0]   src_i,
  input logic [VEC_W-1:0]   dst_i,
  input logic [VEC_W/8-1:0] mask_i,
  input logic               valid_o,
  input logic [VEC_W-1:0]   result_o,
  input logic               err_o
);
  logic [VEC_W-1:0] bmask;
  always_comb
    for (int j = 0; j < VEC_W / 8; j++) bmask[8*j +: 8] = {8{mask_i[j]}};

  a_r9_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r1_masked_bytes_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((result_o ^ $past(dst_i)) & ~$past(bmask)) == '0);

  a_r8_error_passes_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> result_o == $past(dst_i));

  a_r8_bad_code_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) > 3'd5) |-> err_o);

  a_r7_not_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 3'd5) |->
      ((result_o & $past(bmask)) == (~$past(src_i) & $past(bmask))) && !err_o);

  always_comb if (!rst_ni) a_r10_reset_quiet: assert (!valid_o && !err_o);
endmodule

bind vul_unary_lane vul_unary_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .esize_i(esize_i), .src_i(src_i), .dst_i(dst_i), .mask_i(mask_i),
  .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
);

// File: tb/sim_vul_unary_lane.sv
`timescale 1ns/1ps
module sim_vul_unary_lane;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [1:0]   esize_i = '0;
  logic [127:0] src_i = '0, dst_i = '0;
  logic [15:0]  mask_i = '0;
  logic         valid_o, err_o;
  logic [127:0] result_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  vul_unary_lane u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference: {err, raw result}
  function automatic logic [128:0] model(input int op, input int sz, input logic [127:0] s);
    logic [127:0] r;
    logic [63:0]  x;
    logic         e;
    int w, n, u, c, k;
    r = '0; e = 1'b0; w = 8 << sz;
    case (op)
      0, 1: begin
        if (sz == 3) e = 1'b1;
        else for (int el = 0; el < 128 / w; el++) begin
          x = 64'(s >> (el * w)) & ((64'd1 << w) - 64'd1);
          n = 0;
          if (op == 1) begin
            for (int b = w - 1; b >= 0; b--) if (x[b]) break; else n++;
          end else begin
            for (int b = w - 2; b >= 0; b--) if (x[b] != x[w-1]) break; else n++;
          end
          r = r | (128'(n) << (el * w));
        end
      end
      2, 3, 4: begin
        u = 1 << (op - 2); c = 1 << sz;
        if (u >= c) e = 1'b1;
        else for (int j = 0; j < 16; j++) begin
          k = (j / c) * c + (c / u - 1 - (j % c) / u) * u + j % u;
          r[8*j +: 8] = s[8*k +: 8];
        end
      end
      5: r = ~s;
      default: e = 1'b1;
    endcase
    return {e, r};
  endfunction

  task automatic apply(input string req, input int op, input int sz,
                       input logic [127:0] s, input logic [127:0] d, input logic [15:0] m);
    logic [128:0] mo;
    logic [127:0] exp;
    mo = model(op, sz, s);
    for (int j = 0; j < 16; j++)
      exp[8*j +: 8] = (!mo[128] && m[j]) ? mo[8*j +: 8] : d[8*j +: 8];
    @(negedge clk_i);
    op_i = 3'(op); esize_i = 2'(sz); src_i = s; dst_i = d; mask_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " result"}, result_o, exp);
    chk({req, " err"}, 128'(err_o), 128'(mo[128]));
    chk("R9 valid high", 128'(valid_o), 128'd1);
    @(negedge clk_i);
    chk("R9 valid drop", 128'(valid_o), 128'd0);
  endtask

  localparam logic [127:0] PAT = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] OLD = 128'h5a5a_5a5a_a5a5_a5a5_3c3c_3c3c_c3c3_c3c3;
  localparam logic [127:0] CNT = 128'h0000_0001_ffff_0080_ff7f_4000_0100_ff80;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 valid", 128'(valid_o), 0);
    chk("R10 err", 128'(err_o), 0);
    chk("R10 result", result_o, 0);
    rst_ni = 1'b1;
    // R2 leading zeros
    apply("R2 clz8", 1, 0, CNT, OLD, 16'hffff);
    apply("R2 clz16", 1, 1, CNT, OLD, 16'hffff);
    apply("R2 clz32", 1, 2, CNT, OLD, 16'hffff);
    // R3 leading sign bits
    apply("R3 cls8", 0, 0, CNT, OLD, 16'hffff);
    apply("R3 cls16", 0, 1, CNT, OLD, 16'hffff);
    apply("R3 cls32", 0, 2, CNT, OLD, 16'hffff);
    // R4 R5 R6 reversals
    apply("R4 revb16", 2, 1, PAT, OLD, 16'hffff);
    apply("R4 revb32", 2, 2, PAT, OLD, 16'hffff);
    apply("R4 revb64", 2, 3, PAT, OLD, 16'hffff);
    apply("R5 revh32", 3, 2, PAT, OLD, 16'hffff);
    apply("R5 revh64", 3, 3, PAT, OLD, 16'hffff);
    apply("R6 revw64", 4, 3, PAT, OLD, 16'hffff);
    // R1 partial element masks
    apply("R1 revw partial", 4, 3, PAT, OLD, 16'h00f0);
    apply("R1 clz32 partial", 1, 2, CNT, OLD, 16'h3c05);
    apply("R1 none", 2, 2, PAT, OLD, 16'h0000);
    // R7 inversion, size ignored
    apply("R7 not sz0", 5, 0, PAT, OLD, 16'ha5c3);
    apply("R7 not sz3", 5, 3, PAT, OLD, 16'ha5c3);
    // R8 illegal pairings
    apply("R8 clz64", 1, 3, PAT, OLD, 16'hffff);
    apply("R8 cls64", 0, 3, PAT, OLD, 16'hffff);
    apply("R8 revb8", 2, 0, PAT, OLD, 16'hffff);
    apply("R8 revh16", 3, 1, PAT, OLD, 16'hffff);
    apply("R8 revw32", 4, 2, PAT, OLD, 16'hffff);
    apply("R8 op6", 6, 1, PAT, OLD, 16'hffff);
    apply("R8 op7", 7, 2, PAT, OLD, 16'hffff);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule